// File: doc/BRIEF.md
# Multi-Input Wake-Up Event Detector

This block watches a bank of asynchronous wake-up lines, organised as groups of eight, and turns activity on them into latched pending flags and interrupt requests. Every line is first brought into the clock domain by a two-stage synchroniser. Each bit then has its own choice of level or edge detection, an active polarity and an any-edge override. A separate input-enable gate decides whether the bit can detect events at all.

Detected events set per-bit pending flags, which software clears by writing ones. A group raises a request when any pending bit is also interrupt-enabled. Each interrupt output collects the requests of the groups chosen by its own group mask, so one output can serve several groups.

Software reaches all per-group settings and the per-output group masks through a flat register port. The address is the group (or output) index concatenated with a 3-bit field code. Writes take effect on the clock edge where the write strobe is high. Reads are combinational.

Top module: `wake_event_unit`

## Requirements
- R1: After reset every register field reads 0 and every irq output is 0; the zero configuration selects rising-edge detection.
- R2: With mode bit 0, polarity bit 0 and any-edge bit 0, a rising input sets the pending bit, and the flag reads 1 within three clock edges of the input change. A falling input sets nothing.
- R3: In edge mode with polarity bit 1 (any-edge 0), only a falling input sets the pending bit.
- R4: In edge mode with the any-edge bit 1, both rising and falling inputs set the pending bit, whatever the polarity bit holds.
- R5: With mode bit 1, pending is set on every cycle the synchronised input is high (polarity 0) or low (polarity 1). When a clear and a detection hit the same bit in one cycle, the bit stays set.
- R6: Writing field 6 clears each pending bit whose data bit is 1 and leaves bits written 0 untouched. Field 6 reads as 0.
- R7: While a bit's input-enable is 0, its pending bit cannot become set, whatever the input does.
- R8: While input-enable is 0, the bit's edge history is held low. Enabling a bit whose line is already high, in rising or any-edge mode, raises a pending event one edge after the enabling write.
- R9: A group's request is the AND of its pending and interrupt-enable bits. Pending bits still latch while their interrupt-enable is 0.
- R10: Output irq[k] is the OR of the requests of each group g whose bit g is set in mask k. Mask k is written and read at address {k, field 7}, and one output can serve several groups (mask 0x09 serves groups 0 and 3).
- R11: Address = {index, field[2:0]}, with field codes 0 mode, 1 polarity, 2 any-edge, 3 input-enable, 4 interrupt-enable, 5 pending (read-only), 6 clear, 7 group mask. Group g's bit b is wake_in[8*g+b].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | GIDX_W+3 | Register address {index, field} |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| wake_in | input | 8*NUM_GROUPS | Asynchronous wake-up lines |
| irq | output | NUM_IRQ | Aggregated interrupt requests |

## Verification
The detector is tried with single rising pulses, single falling pulses and full pulses on bits set to rising, falling, any-edge, high-level and low-level modes. These show that each mode reacts to exactly its own transition and ignores the opposite one. A level held active while software clears it separates "detection wins" from "clear wins". Toggling a disabled line, and then enabling a line that is already high, separates the input-enable gate from the spurious-event rule. Events latched with interrupts masked, together with group masks that share or split the outputs, show how pending, enable and aggregation differ.

// File: rtl/wake_pkg.sv
package wake_pkg;
    localparam int GRP_BITS = 8;
    localparam int FLD_W    = 3;

    typedef enum logic [FLD_W-1:0] {
        FLD_MODE = 3'd0,
        FLD_POL  = 3'd1,
        FLD_ANY  = 3'd2,
        FLD_INEN = 3'd3,
        FLD_IEN  = 3'd4,
        FLD_PEND = 3'd5,
        FLD_CLR  = 3'd6,
        FLD_IMAP = 3'd7
    } field_e;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage1_q, stage2_q;
    logic [WIDTH-1:0] stage1_d, stage2_d;

    always_comb begin
        stage1_d = async_in;
        stage2_d = stage1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= stage1_d;
            stage2_q <= stage2_d;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import wake_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_BITS-1:0] sync_in,
    input  logic [GRP_BITS-1:0] mode_lvl,
    input  logic [GRP_BITS-1:0] pol_inv,
    input  logic [GRP_BITS-1:0] any_edge,
    input  logic [GRP_BITS-1:0] in_en,
    output logic [GRP_BITS-1:0] hit
);
    logic [GRP_BITS-1:0] hist_q, hist_d;
    logic [GRP_BITS-1:0] gated, rise, fall, edge_hit, lvl_hit;

    always_comb begin
        gated    = sync_in & in_en;
        hist_d   = gated;
        rise     = gated & ~hist_q;
        fall     = ~gated & hist_q;
        edge_hit = (any_edge & (rise | fall))
                 | (~any_edge & ~pol_inv & rise)
                 | (~any_edge & pol_inv & fall);
        lvl_hit  = sync_in ^ pol_inv;
        hit      = in_en & ((mode_lvl & lvl_hit) | (~mode_lvl & edge_hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/wake_irq_merge.sv
module wake_irq_merge #(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_IRQ    = 2
) (
    input  logic [NUM_GROUPS-1:0]              grp_req,
    input  logic [NUM_IRQ-1:0][NUM_GROUPS-1:0] grp_map,
    output logic [NUM_IRQ-1:0]                 irq
);
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
        assign irq[k] = |(grp_req & grp_map[k]);
    end
endmodule

// File: rtl/wake_event_unit.sv
module wake_event_unit
    import wake_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_IRQ    = 2,
    localparam int GIDX_W    = (NUM_GROUPS > NUM_IRQ)
                               ? ((NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1)
                               : ((NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1),
    localparam int ADDR_W    = GIDX_W + FLD_W,
    localparam int LINES     = NUM_GROUPS * GRP_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [LINES-1:0]  wake_in,
    output logic [NUM_IRQ-1:0] irq
);
    typedef logic [NUM_GROUPS-1:0][GRP_BITS-1:0] bank_t;

    typedef struct packed {
        bank_t mode;
        bank_t pol;
        bank_t anye;
        bank_t inen;
        bank_t ien;
        bank_t pend;
        logic [NUM_IRQ-1:0][NUM_GROUPS-1:0] imap;
    } regs_t;

    regs_t r_q, r_d;

    logic [GIDX_W-1:0] idx;
    field_e            fld;
    logic [LINES-1:0]  sync_lines;
    bank_t             hit, clr_mask;
    logic [NUM_GROUPS-1:0] grp_req;

    assign idx = reg_addr[ADDR_W-1:FLD_W];
    assign fld = field_e'(reg_addr[FLD_W-1:0]);

    wake_sync #(.WIDTH(LINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(wake_in),
        .sync_out(sync_lines)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        wake_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .sync_in (sync_lines[g*GRP_BITS +: GRP_BITS]),
            .mode_lvl(r_q.mode[g]),
            .pol_inv (r_q.pol[g]),
            .any_edge(r_q.anye[g]),
            .in_en   (r_q.inen[g]),
            .hit     (hit[g])
        );
        assign grp_req[g] = |(r_q.pend[g] & r_q.ien[g]);
    end

    always_comb begin
        r_d = r_q;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            clr_mask[g] = (reg_wr && idx == GIDX_W'(g) && fld == FLD_CLR)
                          ? reg_wdata : '0;
            if (reg_wr && idx == GIDX_W'(g)) begin
                case (fld)
                    FLD_MODE: r_d.mode[g] = reg_wdata;
                    FLD_POL:  r_d.pol[g]  = reg_wdata;
                    FLD_ANY:  r_d.anye[g] = reg_wdata;
                    FLD_INEN: r_d.inen[g] = reg_wdata;
                    FLD_IEN:  r_d.ien[g]  = reg_wdata;
                    default:  ;
                endcase
            end
            r_d.pend[g] = (r_q.pend[g] & ~clr_mask[g]) | hit[g];
        end
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (reg_wr && idx == GIDX_W'(k) && fld == FLD_IMAP)
                r_d.imap[k] = reg_wdata[NUM_GROUPS-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (idx == GIDX_W'(g)) begin
                case (fld)
                    FLD_MODE: reg_rdata = r_q.mode[g];
                    FLD_POL:  reg_rdata = r_q.pol[g];
                    FLD_ANY:  reg_rdata = r_q.anye[g];
                    FLD_INEN: reg_rdata = r_q.inen[g];
                    FLD_IEN:  reg_rdata = r_q.ien[g];
                    FLD_PEND: reg_rdata = r_q.pend[g];
                    default:  ;
                endcase
            end
        end
        for (int k = 0; k < NUM_IRQ; k++) begin
            if (idx == GIDX_W'(k) && fld == FLD_IMAP)
                reg_rdata = 8'(r_q.imap[k]);
        end
    end

    wake_irq_merge #(.NUM_GROUPS(NUM_GROUPS), .NUM_IRQ(NUM_IRQ)) u_merge (
        .grp_req(grp_req),
        .grp_map(r_q.imap),
        .irq    (irq)
    );

    logic [LINES-1:0] pend_flat, ien_flat, inen_flat, clr_flat, hit_flat;
    assign pend_flat = r_q.pend;
    assign ien_flat  = r_q.ien;
    assign inen_flat = r_q.inen;
    assign clr_flat  = clr_mask;
    assign hit_flat  = hit;
endmodule

// File: rtl/wake_event_checker.sv
module wake_event_checker #(
    parameter int NUM_GROUPS = 4,
    parameter int NUM_IRQ    = 2,
    localparam int LINES     = NUM_GROUPS * 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LINES-1:0]   pend_flat,
    input logic [LINES-1:0]   ien_flat,
    input logic [LINES-1:0]   inen_flat,
    input logic [LINES-1:0]   clr_flat,
    input logic [LINES-1:0]   hit_flat,
    input logic [NUM_IRQ-1:0] irq
);
    for (genvar i = 0; i < LINES; i++) begin : g_bit
        AST_BLOCKED_STAYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (!inen_flat[i] && !pend_flat[i]) |=> !pend_flat[i]); // R7
        AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_flat[i] && !hit_flat[i]) |=> !pend_flat[i]); // R6
        AST_DETECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            hit_flat[i] |=> pend_flat[i]); // R5
        AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_flat[i] && !clr_flat[i]) |=> pend_flat[i]); // R9
    end

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pend_flat & ien_flat) == 0) |-> (irq == '0)); // R10
endmodule

bind wake_event_unit wake_event_checker #(
    .NUM_GROUPS(NUM_GROUPS),
    .NUM_IRQ   (NUM_IRQ)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend_flat(pend_flat),
    .ien_flat (ien_flat),
    .inen_flat(inen_flat),
    .clr_flat (clr_flat),
    .hit_flat (hit_flat),
    .irq      (irq)
);

// File: tb/wake_event_unit_bench.sv
module wake_event_unit_bench;
    localparam int NG = 4;
    localparam int NI = 2;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [NG*8-1:0] wake_in = '0;
    logic [NI-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    wake_event_unit #(.NUM_GROUPS(NG), .NUM_IRQ(NI)) u_wake_event_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wake_in(wake_in), .irq(irq)
    );

    function automatic logic [AW-1:0] adr(int i, int f);
        return {i[1:0], f[2:0]};
    endfunction

    task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(int i, int f, logic [7:0] d);
        @(negedge clk);
        reg_addr = adr(i, f); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_check(string req, int i, int f, logic [7:0] exp);
        reg_addr = adr(i, f);
        #1;
        check8(req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NG; i++)
            for (int f = 0; f < 8; f++) rd_check("R1", i, f, 8'h00);
        check8("R1 irq", 8'(irq), 8'h00);
    endtask

    task automatic t_rise();
        wr(0, 7, 8'h09);
        wr(1, 7, 8'h02);
        rd_check("R10 map0", 0, 7, 8'h09);
        wr(0, 4, 8'h01);
        wr(0, 3, 8'h01);
        wake_in[0] = 1'b1; settle();
        rd_check("R2 rise", 0, 5, 8'h01);
        check8("R10 irq0", 8'(irq), 8'h01);
        wr(0, 6, 8'h01);
        rd_check("R6 clr", 0, 5, 8'h00);
        wake_in[0] = 1'b0; settle();
        rd_check("R2 fall ignored", 0, 5, 8'h00);
    endtask

    task automatic t_fall();
        wr(0, 1, 8'h02);
        wr(0, 3, 8'h03);
        wake_in[1] = 1'b1; settle();
        rd_check("R3 rise ignored", 0, 5, 8'h00);
        wake_in[1] = 1'b0; settle();
        rd_check("R3 fall", 0, 5, 8'h02);
        wr(0, 6, 8'h02);
    endtask

    task automatic t_any();
        wr(0, 2, 8'h04);
        wr(0, 1, 8'h06);
        wr(0, 3, 8'h07);
        wake_in[2] = 1'b1; settle();
        rd_check("R4 rise", 0, 5, 8'h04);
        wr(0, 6, 8'h04);
        wake_in[2] = 1'b0; settle();
        rd_check("R4 fall", 0, 5, 8'h04);
        wr(0, 6, 8'h04);
        rd_check("R4 cleared", 0, 5, 8'h00);
    endtask

    task automatic t_level();
        wr(0, 0, 8'h18);
        wr(0, 1, 8'h16);
        wr(0, 3, 8'h1F);
        settle();
        rd_check("R5 low level", 0, 5, 8'h10);
        wake_in[3] = 1'b1; settle();
        rd_check("R5 high level", 0, 5, 8'h18);
        wr(0, 6, 8'h08);
        rd_check("R5 detect wins", 0, 5, 8'h18);
        wake_in[3] = 1'b0; wake_in[4] = 1'b1; settle();
        wr(0, 6, 8'h18);
        rd_check("R5 released", 0, 5, 8'h00);
    endtask

    task automatic t_clear();
        wr(1, 3, 8'hFF);
        wake_in[8] = 1'b1; wake_in[9] = 1'b1; settle();
        rd_check("R9 latch masked", 1, 5, 8'h03);
        check8("R9 irq masked", 8'(irq), 8'h00);
        wr(1, 6, 8'h00);
        rd_check("R6 zero no effect", 1, 5, 8'h03);
        rd_check("R6 clr reads 0", 1, 6, 8'h00);
        wr(1, 6, 8'h01);
        rd_check("R6 single", 1, 5, 8'h02);
        wr(1, 4, 8'h02);
        check8("R9 irq1", 8'(irq), 8'h02);
        wr(1, 6, 8'h02);
        check8("R9 irq off", 8'(irq), 8'h00);
        wake_in[8] = 1'b0; wake_in[9] = 1'b0; settle();
        rd_check("R2 no fall g1", 1, 5, 8'h00);
    endtask

    task automatic t_block();
        wake_in[16] = 1'b1; settle();
        wake_in[16] = 1'b0; settle();
        wake_in[16] = 1'b1; settle();
        rd_check("R7 blocked", 2, 5, 8'h00);
    endtask

    task automatic t_spur();
        wr(2, 3, 8'h01);
        @(negedge clk);
        rd_check("R8 spurious", 2, 5, 8'h01);
        wr(2, 6, 8'h01);
        wake_in[16] = 1'b0; settle();
        rd_check("R8 cleared", 2, 5, 8'h00);
    endtask

    task automatic t_share();
        wr(3, 3, 8'h01);
        wr(3, 4, 8'h01);
        wake_in[24] = 1'b1; settle();
        check8("R10 shared g3", 8'(irq), 8'h01);
        wr(1, 7, 8'h08);
        rd_check("R11 map1", 1, 7, 8'h08);
        check8("R10 both", 8'(irq), 8'h03);
        wr(3, 6, 8'h01);
        check8("R10 idle", 8'(irq), 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rise();
        t_fall();
        t_any();
        t_level();
        t_clear();
        t_block();
        t_spur();
        t_share();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule